// File: doc/BRIEF.md
# Ping-Pong Bulk Endpoint Controller

This block runs one bulk endpoint that moves data in a single direction through two packet buffers. The hardware side fills buffer A (receive) or drains it (transmit) while application software works on buffer B. After each successful transaction the hardware moves to the other buffer. A hardware toggle bit selects the buffer the hardware uses. The toggle bit of the unused direction becomes a software flag that names the buffer software holds. The endpoint answers NAK only while both point at the same buffer, so a fast application never sees a NAK between packets.

Software sees one control word and four descriptor words through a plain register port. The control word holds a two-bit status field for each direction, at most one of them non-zero, and the two toggle bits. The descriptor words hold an address and a length for each buffer. The serial engine hands each finished token to the block on a valid/ready stream. The token carries its direction, the received byte count and whether the transaction was good. The block answers on a second valid/ready stream with an outcome code, the buffer it used, the buffer address and the byte length. Back-pressure rules: a token is taken only when `tok_valid` and `tok_ready` are both high at a clock edge. `tok_ready` is low while an answer is waiting and in any cycle with a register write. An answer stays on `hs_*` unchanged until `hs_ready` is high at an edge.

Top module: `bulk_pingpong_ep`

## Requirements
- R1: After reset the control word reads 0, the descriptor words read 0, `hs_valid` is 0 and `tok_ready` is 1.
- R2: Control word (register index 0) layout: receive toggle at bit 14, receive status at bits 13:12, transmit toggle at bit 6, transmit status at bits 5:4, all other bits read 0. Status codes are 00 off, 01 stall, 10 NAK and 11 valid. A write replaces both status fields, unless it would make both non-zero; then both fields keep their old values. Descriptor words sit at index 1 (buffer 0 address), 2 (buffer 0 length), 3 (buffer 1 address) and 4 (buffer 1 length).
- R3: Writing 1 to a toggle bit inverts it, and writing 0 leaves it unchanged.
- R4: The active direction is receive when its status is non-zero, and transmit otherwise. The hardware toggle is the active direction's toggle bit, and the software flag is the other toggle bit. A token in the active direction is accepted with outcome ACK (code 0) when the status is valid, there is no conflict and the token is good. The answer reports the old hardware toggle as `hs_buf`, and that buffer's address. The hardware toggle then inverts.
- R5: A receive ACK writes the token byte count into the length word of the buffer just filled, and reports that count as `hs_len`. Every other answer reports the length word of the reported buffer.
- R6: A conflict exists when the status is valid and the hardware toggle equals the software flag. During a conflict the active status field reads 10, tokens get outcome NAK (code 1), and neither the toggle nor any descriptor changes.
- R7: A stored status of NAK gives outcome NAK, and a stored status of stall gives outcome STALL (code 2). Neither changes any state.
- R8: A token that arrives while both status fields are off, a token in the wrong direction, or a bad token to a valid endpoint gets outcome NONE (code 3), and no state changes.
- R9: The answer appears one cycle after the token is taken, and holds steady until it is taken. `tok_ready` is low while `hs_valid` or `reg_wr` is high.
- R10: When software inverts its flag during a conflict, the status reads valid again, and the next good token is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control, 1..4 descriptors) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| tok_valid | input | 1 | Finished token is offered |
| tok_ready | output | 1 | Block can take a token |
| tok_in | input | 1 | Token direction: 1 transmit (IN), 0 receive (OUT) |
| tok_count | input | LEN_W | Received byte count |
| tok_good | input | 1 | Transaction completed without error |
| hs_valid | output | 1 | Answer is present |
| hs_ready | input | 1 | Consumer takes the answer |
| hs_code | output | 2 | Outcome: 0 ACK, 1 NAK, 2 STALL, 3 NONE |
| hs_buf | output | 1 | Buffer the token addressed |
| hs_addr | output | ADDR_W | Address of that buffer |
| hs_len | output | LEN_W | Byte length (see R5) |

## Verification
The bench drives the endpoint through two back-to-back conflicts in receive mode and one in transmit mode. A design that compared the software flag with the pre-swap toggle, or that kept swapping while NAKing, would report the wrong buffer on the next token. It checks that a NAK or bad token leaves the length word and the toggle untouched. A design that updated the length before deciding the outcome would overwrite software's count. It writes both status fields non-zero and expects the old status back. It stalls the answer stream to catch an answer that changes or a token that is taken while a previous answer is still waiting.

// File: rtl/bulk_pingpong_pkg.sv
package bulk_pingpong_pkg;
  typedef enum logic [1:0] {
    OUTC_ACK   = 2'd0,
    OUTC_NAK   = 2'd1,
    OUTC_STALL = 2'd2,
    OUTC_NONE  = 2'd3
  } outcome_t;

  localparam logic [1:0] ST_OFF   = 2'b00;
  localparam logic [1:0] ST_STALL = 2'b01;
  localparam logic [1:0] ST_NAK   = 2'b10;
  localparam logic [1:0] ST_VALID = 2'b11;

  localparam int REG_W     = 16;
  localparam int BIT_RXTOG = 14;
  localparam int BIT_RXST  = 12;
  localparam int BIT_TXTOG = 6;
  localparam int BIT_TXST  = 4;
  localparam int NBUF      = 2;
endpackage

// File: rtl/pp_ctrl_reg.sv
module pp_ctrl_reg
  import bulk_pingpong_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             flip_hw,
  output logic [1:0]       act_stat,
  output logic             active,
  output logic             dir_tx,
  output logic             hw_tog,
  output logic             sw_flag,
  output logic             conflict,
  output logic [REG_W-1:0] ctrl_word
);
  logic [1:0] rx_st_q, tx_st_q;
  logic       rx_tog_q, tx_tog_q;
  logic [1:0] w_rx, w_tx;

  assign w_rx = wdata[BIT_RXST +: 2];
  assign w_tx = wdata[BIT_TXST +: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st_q  <= ST_OFF;
      tx_st_q  <= ST_OFF;
      rx_tog_q <= 1'b0;
      tx_tog_q <= 1'b0;
    end else if (wr_en) begin
      if (!((w_rx != ST_OFF) && (w_tx != ST_OFF))) begin
        rx_st_q <= w_rx;
        tx_st_q <= w_tx;
      end
      rx_tog_q <= rx_tog_q ^ wdata[BIT_RXTOG];
      tx_tog_q <= tx_tog_q ^ wdata[BIT_TXTOG];
    end else if (flip_hw) begin
      if (dir_tx) tx_tog_q <= ~tx_tog_q;
      else        rx_tog_q <= ~rx_tog_q;
    end
  end

  assign dir_tx   = (rx_st_q == ST_OFF) && (tx_st_q != ST_OFF);
  assign active   = (rx_st_q != ST_OFF) || (tx_st_q != ST_OFF);
  assign act_stat = dir_tx ? tx_st_q : rx_st_q;
  assign hw_tog   = dir_tx ? tx_tog_q : rx_tog_q;
  assign sw_flag  = dir_tx ? rx_tog_q : tx_tog_q;
  assign conflict = (act_stat == ST_VALID) && (hw_tog == sw_flag);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_RXTOG]     = rx_tog_q;
    ctrl_word[BIT_TXTOG]     = tx_tog_q;
    ctrl_word[BIT_RXST +: 2] = rx_st_q;
    ctrl_word[BIT_TXST +: 2] = tx_st_q;
    if (conflict) begin
      if (dir_tx) ctrl_word[BIT_TXST +: 2] = ST_NAK;
      else        ctrl_word[BIT_RXST +: 2] = ST_NAK;
    end
  end
endmodule

// File: rtl/pp_desc_table.sv
module pp_desc_table
  import bulk_pingpong_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_idx,
  input  logic [REG_W-1:0]           wdata,
  input  logic                       upd_en,
  input  logic                       upd_buf,
  input  logic [LEN_W-1:0]           upd_len,
  output logic [NBUF-1:0][ADDR_W-1:0] addr_o,
  output logic [NBUF-1:0][LEN_W-1:0]  len_o
);
  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    localparam logic [2:0] IDX_ADDR = 3'(1 + 2*b);
    localparam logic [2:0] IDX_LEN  = 3'(2 + 2*b);
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q <= '0;
        len_q  <= '0;
      end else begin
        if (wr_en && wr_idx == IDX_ADDR) addr_q <= wdata[ADDR_W-1:0];
        if (wr_en && wr_idx == IDX_LEN) len_q <= wdata[LEN_W-1:0];
        else if (upd_en && upd_buf == 1'(b)) len_q <= upd_len;
      end
    end

    assign addr_o[b] = addr_q;
    assign len_o[b]  = len_q;
  end
endmodule

// File: rtl/pp_xact.sv
module pp_xact
  import bulk_pingpong_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic                        tok_in,
  input  logic [LEN_W-1:0]            tok_count,
  input  logic                        tok_good,
  input  logic [1:0]                  act_stat,
  input  logic                        active,
  input  logic                        dir_tx,
  input  logic                        hw_tog,
  input  logic                        conflict,
  input  logic [NBUF-1:0][ADDR_W-1:0] addr_i,
  input  logic [NBUF-1:0][LEN_W-1:0]  len_i,
  input  logic                        hs_ready,
  output logic                        hs_valid,
  output outcome_t                    hs_code,
  output logic                        hs_buf,
  output logic [ADDR_W-1:0]           hs_addr,
  output logic [LEN_W-1:0]            hs_len,
  output logic                        flip_hw,
  output logic                        upd_en
);
  outcome_t nxt_code;
  logic     dir_ok;

  assign dir_ok = active && (tok_in == dir_tx);

  always_comb begin
    nxt_code = OUTC_NONE;
    if (dir_ok) begin
      unique case (act_stat)
        ST_STALL: nxt_code = OUTC_STALL;
        ST_NAK:   nxt_code = OUTC_NAK;
        ST_VALID: nxt_code = conflict ? OUTC_NAK : (tok_good ? OUTC_ACK : OUTC_NONE);
        default:  nxt_code = OUTC_NONE;
      endcase
    end
  end

  assign flip_hw = take && (nxt_code == OUTC_ACK);
  assign upd_en  = flip_hw && !dir_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= OUTC_NONE;
      hs_buf   <= 1'b0;
      hs_addr  <= '0;
      hs_len   <= '0;
    end else if (take) begin
      hs_valid <= 1'b1;
      hs_code  <= nxt_code;
      hs_buf   <= hw_tog;
      hs_addr  <= addr_i[hw_tog];
      hs_len   <= upd_en ? tok_count : len_i[hw_tog];
    end else if (hs_valid && hs_ready) begin
      hs_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bulk_pingpong_ep.sv
module bulk_pingpong_ep
  import bulk_pingpong_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic              tok_in,
  input  logic [LEN_W-1:0]  tok_count,
  input  logic              tok_good,
  output logic              hs_valid,
  input  logic              hs_ready,
  output logic [1:0]        hs_code,
  output logic              hs_buf,
  output logic [ADDR_W-1:0] hs_addr,
  output logic [LEN_W-1:0]  hs_len
);
  logic                        ctrl_wr, take, flip_hw, upd_en;
  logic [1:0]                  act_stat;
  logic                        active, dir_tx, hw_tog, sw_flag, conflict;
  logic [REG_W-1:0]            ctrl_word;
  logic [NBUF-1:0][ADDR_W-1:0] addr_w;
  logic [NBUF-1:0][LEN_W-1:0]  len_w;
  outcome_t                    code_w;

  assign ctrl_wr   = reg_wr && (reg_addr == 3'd0);
  assign tok_ready = !hs_valid && !reg_wr;
  assign take      = tok_valid && tok_ready;
  assign hs_code   = code_w;

  pp_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(reg_wdata),
    .flip_hw(flip_hw), .act_stat(act_stat), .active(active), .dir_tx(dir_tx),
    .hw_tog(hw_tog), .sw_flag(sw_flag), .conflict(conflict), .ctrl_word(ctrl_word)
  );

  pp_desc_table #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_desc (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_idx(reg_addr), .wdata(reg_wdata),
    .upd_en(upd_en), .upd_buf(hw_tog), .upd_len(tok_count),
    .addr_o(addr_w), .len_o(len_w)
  );

  pp_xact #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_xact (
    .clk(clk), .rst_n(rst_n), .take(take), .tok_in(tok_in), .tok_count(tok_count),
    .tok_good(tok_good), .act_stat(act_stat), .active(active), .dir_tx(dir_tx),
    .hw_tog(hw_tog), .conflict(conflict), .addr_i(addr_w), .len_i(len_w),
    .hs_ready(hs_ready), .hs_valid(hs_valid), .hs_code(code_w), .hs_buf(hs_buf),
    .hs_addr(hs_addr), .hs_len(hs_len), .flip_hw(flip_hw), .upd_en(upd_en)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      3'd0:    reg_rdata = ctrl_word;
      3'd1:    reg_rdata[ADDR_W-1:0] = addr_w[0];
      3'd2:    reg_rdata[LEN_W-1:0]  = len_w[0];
      3'd3:    reg_rdata[ADDR_W-1:0] = addr_w[1];
      3'd4:    reg_rdata[LEN_W-1:0]  = len_w[1];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bulk_pingpong_chk.sv
module bulk_pingpong_chk #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [15:0]       reg_rdata,
  input logic              tok_valid,
  input logic              tok_ready,
  input logic              tok_in,
  input logic              hs_valid,
  input logic              hs_ready,
  input logic [1:0]        hs_code,
  input logic              hs_buf,
  input logic [ADDR_W-1:0] hs_addr,
  input logic [LEN_W-1:0]  hs_len,
  input logic              hw_tog,
  input logic              conflict,
  input logic              active,
  input logic              dir_tx
);
  AST_HOLD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && !hs_ready) |=> (hs_valid && $stable(hs_code) && $stable(hs_buf) && $stable(hs_addr) && $stable(hs_len))); // R9

  AST_ANSWER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready) |=> hs_valid); // R9

  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid || reg_wr) |-> !tok_ready); // R9

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> !((reg_rdata[13:12] != 2'b00) && (reg_rdata[5:4] != 2'b00))); // R2

  AST_SWAP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready) |=> ((hs_code == 2'd0) == (hw_tog != $past(hw_tog)))); // R4

  AST_CONFLICT_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready && conflict && active && (tok_in == dir_tx)) |=> (hs_code == 2'd1)); // R6
endmodule

bind bulk_pingpong_ep bulk_pingpong_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_in(tok_in), .hs_valid(hs_valid),
  .hs_ready(hs_ready), .hs_code(hs_code), .hs_buf(hs_buf), .hs_addr(hs_addr),
  .hs_len(hs_len), .hw_tog(hw_tog), .conflict(conflict), .active(active), .dir_tx(dir_tx)
);

// File: tb/bulk_pingpong_ep_test.sv
module bulk_pingpong_ep_test;
  localparam int AW = 16;
  localparam int LW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic          tok_valid = 1'b0;
  logic          tok_ready;
  logic          tok_in = 1'b0;
  logic [LW-1:0] tok_count = '0;
  logic          tok_good = 1'b0;
  logic          hs_valid;
  logic          hs_ready = 1'b1;
  logic [1:0]    hs_code;
  logic          hs_buf;
  logic [AW-1:0] hs_addr;
  logic [LW-1:0] hs_len;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [1:0]    code;
    logic          bufsel;
    logic [AW-1:0] addr;
    logic [LW-1:0] len;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  bulk_pingpong_ep #(.ADDR_W(AW), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_valid(tok_valid),
    .tok_ready(tok_ready), .tok_in(tok_in), .tok_count(tok_count),
    .tok_good(tok_good), .hs_valid(hs_valid), .hs_ready(hs_ready),
    .hs_code(hs_code), .hs_buf(hs_buf), .hs_addr(hs_addr), .hs_len(hs_len)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected answer when the design hands one over
  always @(negedge clk) begin
    if (rst_n && hs_valid && hs_ready) begin
      if (sb.size() == 0) begin
        check("R9 unexpected answer", 32'(hs_code), 32'hFFFF);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " code"}, 32'(hs_code), 32'(e.code));
        check({e.tag, " buf"},  32'(hs_buf),  32'(e.bufsel));
        check({e.tag, " addr"}, 32'(hs_addr), 32'(e.addr));
        check({e.tag, " len"},  32'(hs_len),  32'(e.len));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #4;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    check("R9 tok_ready low during write", 32'(tok_ready), 32'd0);
    @(posedge clk); #4;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [15:0] exp);
    @(posedge clk); #4;
    reg_addr = a;
    @(negedge clk);
    check(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic send(input logic in_dir, input int cnt, input logic good,
                      input logic [1:0] code, input logic bsel,
                      input logic [AW-1:0] addr, input logic [LW-1:0] len,
                      input string tag);
    exp_t e;
    e.code = code; e.bufsel = bsel; e.addr = addr; e.len = len; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #4;
    tok_valid = 1'b1; tok_in = in_dir; tok_count = LW'(cnt); tok_good = good;
    @(negedge clk);
    while (!tok_ready) @(negedge clk);
    @(posedge clk); #4;
    tok_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #4 rst_n = 1'b1;
    @(negedge clk);
    check("R1 hs_valid", 32'(hs_valid), 32'd0);
    check("R1 tok_ready", 32'(tok_ready), 32'd1);
    rd("R1 ctrl", 3'd0, 16'h0000);
    rd("R1 len1", 3'd4, 16'h0000);

    wr(3'd1, 16'h0040); wr(3'd3, 16'h0080);
    rd("R2 addr1", 3'd3, 16'h0080);

    // disabled endpoint
    send(1'b0, 5, 1'b1, 2'd3, 1'b0, 16'h0040, 10'd0, "R8 disabled");
    drain();

    // receive valid, software flag inverted to 1
    wr(3'd0, 16'h3040);
    rd("R2 R3 ctrl setup", 3'd0, 16'h3040);
    send(1'b0, 64, 1'b1, 2'd0, 1'b0, 16'h0040, 10'd64, "R4 R5 rx ack buf0");
    drain();
    rd("R6 conflict readback", 3'd0, 16'h6040);
    rd("R5 len0 updated", 3'd2, 16'd64);
    send(1'b0, 7, 1'b1, 2'd1, 1'b1, 16'h0080, 10'd0, "R6 conflict nak");
    drain();
    rd("R6 toggle held", 3'd0, 16'h6040);
    rd("R6 len1 untouched", 3'd4, 16'd0);

    // software frees its buffer
    wr(3'd0, 16'h3040);
    rd("R10 resume", 3'd0, 16'h7000);
    send(1'b0, 10, 1'b1, 2'd0, 1'b1, 16'h0080, 10'd10, "R10 rx ack buf1");
    drain();
    rd("R6 second conflict", 3'd0, 16'h2000);
    rd("R5 len1 updated", 3'd4, 16'd10);

    // bad token and wrong direction
    wr(3'd0, 16'h3040);
    send(1'b0, 99, 1'b0, 2'd3, 1'b0, 16'h0040, 10'd64, "R8 bad token");
    send(1'b1, 3, 1'b1, 2'd3, 1'b0, 16'h0040, 10'd64, "R8 wrong direction");
    drain();
    rd("R8 ctrl unchanged", 3'd0, 16'h3040);
    rd("R8 len0 unchanged", 3'd2, 16'd64);

    // stored NAK and STALL
    wr(3'd0, 16'h2000);
    send(1'b0, 4, 1'b1, 2'd1, 1'b0, 16'h0040, 10'd64, "R7 stored nak");
    drain();
    rd("R7 nak no change", 3'd0, 16'h2040);
    wr(3'd0, 16'h1000);
    send(1'b0, 4, 1'b1, 2'd2, 1'b0, 16'h0040, 10'd64, "R7 stall");
    drain();

    // both status fields non-zero rejected
    wr(3'd0, 16'h3030);
    rd("R2 both fields rejected", 3'd0, 16'h1040);

    // transmit direction
    wr(3'd0, 16'h0030);
    rd("R2 R4 tx setup", 3'd0, 16'h0070);
    wr(3'd4, 16'd20);
    send(1'b1, 0, 1'b1, 2'd0, 1'b1, 16'h0080, 10'd20, "R4 R5 tx ack buf1");
    drain();
    rd("R6 tx conflict", 3'd0, 16'h0020);

    // back-pressure on the answer
    wr(3'd0, 16'h4030);
    rd("R10 tx resume", 3'd0, 16'h4030);
    @(posedge clk); #4 hs_ready = 1'b0;
    send(1'b1, 0, 1'b1, 2'd0, 1'b0, 16'h0040, 10'd64, "R9 held answer");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 answer held", 32'(hs_valid), 32'd1);
      check("R9 code held", 32'(hs_code), 32'd0);
      check("R9 no token while busy", 32'(tok_ready), 32'd0);
    end
    @(posedge clk); #4 hs_ready = 1'b1;
    drain();
    rd("R4 tx after swap", 3'd0, 16'h4060);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule